// File: doc/BRIEF.md
# Tournament Conditional Branch Predictor

This block forecasts whether a conditional branch will be taken. It runs two predictors side by side. The local side is two-level: a per-branch history of recent outcomes, selected by low program-counter bits, addresses a table of 3-bit saturating counters. The global side keeps one shift register of the most recent resolved outcomes across all branches. That history addresses a table of 2-bit counters and, with the same index, a chooser table of 2-bit counters that decides which side to believe.

A lookup presents a branch address. One cycle later the block returns the final prediction and a checkpoint: both component predictions, the local history pattern and the global history it used. The pipeline carries that checkpoint with the branch. When the branch resolves, the checkpoint and the real outcome come back on the update port. Training then reaches exactly the entries that made the prediction, whatever the histories have become since. Asserting reset, as on a context switch, clears every table and both histories.

Top module: `tbp_top`

## Requirements
- R1: While reset is low at a clock edge, every counter, every local history entry and the global history become zero. After that, a lookup predicts not-taken with both histories reported as zero.
- R2: `pred_valid` is high in exactly the cycle after a cycle with `lk_valid` high. The prediction outputs belong to that lookup.
- R3: The local history entry is chosen by `lk_pc`, and its value chooses one of the 3-bit local counters. `pred_local` is that counter's top bit, so values 4 to 7 mean taken.
- R4: The global history value chooses one of the 2-bit global counters. `pred_global` is that counter's top bit, so values 2 and 3 mean taken.
- R5: The global history value also chooses a 2-bit chooser counter. When its top bit is set, `pred_taken` equals `pred_global`; otherwise it equals `pred_local`.
- R6: Every counter saturates. A step up at the maximum value and a step down at zero leave it unchanged; any other step changes it by exactly one.
- R7: An update steps the local counter at `up_lhist` and the global counter at `up_ghist` toward `up_taken`. It uses the returned checkpoint, not the current histories.
- R8: The chooser counter at `up_ghist` changes only when `up_local` differs from `up_global`. It steps up when the global side was right and down when the local side was right.
- R9: On each update the global history shifts left, taking `up_taken` into bit 0. The local history entry at `up_pc` also shifts left, taking `up_taken` into its bit 0. Without an update, the global history holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all tables and histories |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | PC_IDX_W (10) | Branch address bits that select the local history entry |
| pred_valid | output | 1 | Prediction present, one cycle after lookup |
| pred_taken | output | 1 | Final direction prediction |
| pred_local | output | 1 | Local side prediction (checkpoint) |
| pred_global | output | 1 | Global side prediction (checkpoint) |
| pred_lhist | output | LHIST_W (10) | Local history used (checkpoint) |
| pred_ghist | output | GHIST_W (12) | Global history used (checkpoint) |
| up_valid | input | 1 | Resolved-branch update |
| up_pc | input | PC_IDX_W (10) | Address bits of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_lhist | input | LHIST_W (10) | Local history from the checkpoint |
| up_ghist | input | GHIST_W (12) | Global history from the checkpoint |
| up_local | input | 1 | Local prediction from the checkpoint |
| up_global | input | 1 | Global prediction from the checkpoint |

## Verification
The bench builds the block with its default parameters: 10-bit branch index, 10-bit local histories, 3-bit local counters and a 12-bit global history. At these sizes one branch with an alternating outcome sits beside a noisy branch, and the local side learns the alternating one. A second pair of branches repeats each other's outcome, so the global side and the chooser learn the link while the local side cannot. Saturation at both counter ends is reached with long one-sided runs. A reset in the middle of the run shows that learned state is cleared.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  // Saturating step of a counter that is w bits wide (w <= 8)
  function automatic logic [7:0] ctr_step(input logic [7:0] v, input logic up,
                                          input int unsigned w);
    logic [7:0] top;
    top = 8'((16'd1 << w) - 16'd1);
    if (up) return (v == top) ? v : v + 8'd1;
    else    return (v == 8'd0) ? v : v - 8'd1;
  endfunction

  // Direction encoded by a counter: its most significant bit
  function automatic logic ctr_dir(input logic [7:0] v, input int unsigned w);
    return v[w-1];
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  import tbp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX = {CTR_W{1'b1}};

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] wr_cur;
  logic [CTR_W-1:0] wr_nxt;

  assign rd_ctr = mem[rd_idx];
  assign wr_cur = mem[wr_idx];
  assign wr_nxt = CTR_W'(ctr_step(8'(wr_cur), wr_up, CTR_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_nxt;
    end
  end

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && wr_cur == CMAX) |=> mem[$past(wr_idx)] == CMAX); // R6
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && wr_cur == '0) |=> mem[$past(wr_idx)] == '0); // R6
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && wr_cur != CMAX) |=> mem[$past(wr_idx)] == $past(wr_cur) + 1'b1); // R6
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && wr_cur != '0) |=> mem[$past(wr_idx)] == $past(wr_cur) - 1'b1); // R6
  AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> mem[$past(wr_idx)] == $past(wr_cur)); // R8

endmodule

// File: rtl/tbp_hist_table.sv
module tbp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];
  logic [HIST_W-1:0] wr_cur;

  assign rd_hist = mem[rd_idx];
  assign wr_cur  = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {wr_cur[HIST_W-2:0], wr_bit};
    end
  end

  AST_LHIST_NEWBIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)][0] == $past(wr_bit)); // R9
  AST_LHIST_AGED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)][1] == $past(wr_cur[0])); // R9

endmodule

// File: rtl/tbp_top.sv
module tbp_top #(
  parameter int PC_IDX_W = 10,
  parameter int LHIST_W  = 10,
  parameter int LCTR_W   = 3,
  parameter int GHIST_W  = 12,
  parameter int GCTR_W   = 2,
  parameter int CCTR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [PC_IDX_W-1:0] lk_pc,
  output logic                pred_valid,
  output logic                pred_taken,
  output logic                pred_local,
  output logic                pred_global,
  output logic [LHIST_W-1:0]  pred_lhist,
  output logic [GHIST_W-1:0]  pred_ghist,
  input  logic                up_valid,
  input  logic [PC_IDX_W-1:0] up_pc,
  input  logic                up_taken,
  input  logic [LHIST_W-1:0]  up_lhist,
  input  logic [GHIST_W-1:0]  up_ghist,
  input  logic                up_local,
  input  logic                up_global
);
  import tbp_pkg::*;

  logic [GHIST_W-1:0] ghist;
  logic [LHIST_W-1:0] lk_lhist;
  logic [LCTR_W-1:0]  lk_lctr;
  logic [GCTR_W-1:0]  lk_gctr;
  logic [CCTR_W-1:0]  lk_cctr;

  // named internal events
  logic lk_local, lk_global, lk_use_global, lk_final;
  logic ch_train, ch_toward_global;

  tbp_hist_table #(.IDX_W(PC_IDX_W), .HIST_W(LHIST_W)) u_lhist (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_pc), .rd_hist(lk_lhist),
    .wr_en(up_valid), .wr_idx(up_pc), .wr_bit(up_taken));

  tbp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_lctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_lhist), .rd_ctr(lk_lctr),
    .wr_en(up_valid), .wr_idx(up_lhist), .wr_up(up_taken));

  tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_ctr(lk_gctr),
    .wr_en(up_valid), .wr_idx(up_ghist), .wr_up(up_taken));

  tbp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CCTR_W)) u_choice (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist), .rd_ctr(lk_cctr),
    .wr_en(ch_train), .wr_idx(up_ghist), .wr_up(ch_toward_global));

  assign lk_local      = ctr_dir(8'(lk_lctr), LCTR_W);
  assign lk_global     = ctr_dir(8'(lk_gctr), GCTR_W);
  assign lk_use_global = ctr_dir(8'(lk_cctr), CCTR_W);
  assign lk_final      = lk_use_global ? lk_global : lk_local;

  assign ch_train         = up_valid && (up_local != up_global);
  assign ch_toward_global = (up_global == up_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghist <= '0;
    end else if (up_valid) begin
      ghist <= {ghist[GHIST_W-2:0], up_taken};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid  <= 1'b0;
      pred_taken  <= 1'b0;
      pred_local  <= 1'b0;
      pred_global <= 1'b0;
      pred_lhist  <= '0;
      pred_ghist  <= '0;
    end else begin
      pred_valid <= lk_valid;
      if (lk_valid) begin
        pred_taken  <= lk_final;
        pred_local  <= lk_local;
        pred_global <= lk_global;
        pred_lhist  <= lk_lhist;
        pred_ghist  <= ghist;
      end
    end
  end

  AST_PRED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid); // R2
  AST_PRED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid); // R2
  AST_PRED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_taken != pred_local) |-> pred_taken == pred_global); // R5
  AST_GHIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist[0] == $past(up_taken) && ghist[1] == $past(ghist[0])); // R9
  AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist)); // R9
  AST_CHOICE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_local == up_global) |-> !ch_train); // R8

endmodule

// File: tb/tbp_top_tb.sv
`timescale 1ns/1ps
module tbp_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [9:0] lk_pc = '0;
  logic pred_valid, pred_taken, pred_local, pred_global;
  logic [9:0] pred_lhist;
  logic [11:0] pred_ghist;
  logic up_valid = 1'b0;
  logic [9:0] up_pc = '0;
  logic up_taken = 1'b0;
  logic [9:0] up_lhist = '0;
  logic [11:0] up_ghist = '0;
  logic up_local = 1'b0;
  logic up_global = 1'b0;

  always #4 clk = ~clk;

  tbp_top u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_local(pred_local),
    .pred_global(pred_global), .pred_lhist(pred_lhist), .pred_ghist(pred_ghist),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_lhist(up_lhist),
    .up_ghist(up_ghist), .up_local(up_local), .up_global(up_global));

  // reference model
  int m_lh[1024];
  int m_lc[1024];
  int m_gc[4096];
  int m_cc[4096];
  int m_gh;

  typedef struct {
    bit taken; bit loc; bit glob; int lh; int gh;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int sat(int v, bit up, int mx);
    if (up) return (v >= mx) ? mx : v + 1;
    return (v <= 0) ? 0 : v - 1;
  endfunction

  task automatic model_clear();
    foreach (m_lh[i]) begin m_lh[i] = 0; m_lc[i] = 0; end
    foreach (m_gc[i]) begin m_gc[i] = 0; m_cc[i] = 0; end
    m_gh = 0;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // monitor: pops expected items as predictions appear
  always @(negedge clk) begin
    if (rst_n && pred_valid) begin
      if (q.size() == 0) chk(0, "R2 unexpected pred_valid", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(pred_taken == e.taken, "R5 R8 taken", pred_taken, e.taken);
        chk(pred_local == e.loc, "R3 R7 local", pred_local, e.loc);
        chk(pred_global == e.glob, "R4 R7 global", pred_global, e.glob);
        chk(pred_lhist == 10'(e.lh), "R9 lhist", pred_lhist, e.lh);
        chk(pred_ghist == 12'(e.gh), "R9 ghist", pred_ghist, e.gh);
      end
    end
  end

  // driver: lookup, then resolve with the model's checkpoint
  task automatic branch(int pc, bit outcome, output bit got);
    exp_t e;
    @(negedge clk);
    e.lh = m_lh[pc];
    e.gh = m_gh;
    e.loc = (m_lc[e.lh] >= 4);
    e.glob = (m_gc[e.gh] >= 2);
    e.taken = (m_cc[e.gh] >= 2) ? e.glob : e.loc;
    q.push_back(e);
    lk_valid = 1'b1; lk_pc = 10'(pc);
    @(posedge clk); @(negedge clk);
    lk_valid = 1'b0;
    got = pred_taken;
    up_valid = 1'b1; up_pc = 10'(pc); up_taken = outcome;
    up_lhist = 10'(e.lh); up_ghist = 12'(e.gh); up_local = e.loc; up_global = e.glob;
    m_lc[e.lh] = sat(m_lc[e.lh], outcome, 7);
    m_gc[e.gh] = sat(m_gc[e.gh], outcome, 3);
    if (e.loc != e.glob) m_cc[e.gh] = sat(m_cc[e.gh], e.glob == outcome, 3);
    m_lh[pc] = ((m_lh[pc] << 1) | int'(outcome)) & 1023;
    m_gh = ((m_gh << 1) | int'(outcome)) & 4095;
    @(posedge clk); @(negedge clk);
    up_valid = 1'b0;
    chk(pred_valid == 1'b0, "R2 no lookup", pred_valid, 0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    model_clear();
    q.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    bit got;
    int good;
    model_clear();
    do_reset();
    chk(pred_valid == 1'b0, "R1 reset pred_valid", pred_valid, 0);

    // R1: cleared tables predict not-taken
    branch(3, 1'b1, got);
    chk(got == 1'b0, "R1 first prediction", got, 0);

    // R3: alternating branch beside a noisy one
    good = 0;
    for (int i = 0; i < 300; i++) begin
      bit o;
      o = i[0];
      branch(9, rnd(), got);
      branch(5, o, got);
      if (i >= 280) chk(got == o, "R3 alternating learned", got, o);
    end

    // R6: saturation at the top, then at the bottom
    for (int i = 0; i < 40; i++) branch(11, 1'b1, got);
    chk(got == 1'b1, "R6 saturated taken", got, 1);
    for (int i = 0; i < 40; i++) branch(11, 1'b0, got);
    chk(got == 1'b0, "R6 saturated not-taken", got, 0);

    // R4: correlated pair, learned through global history and chooser
    good = 0;
    for (int i = 0; i < 1500; i++) begin
      bit a;
      a = rnd();
      branch(100, a, got);
      branch(200, a, got);
      if (i >= 1200 && got == a) good++;
    end
    chk(good >= 240, "R4 R5 correlated accuracy", good, 240);

    // R1: reset in mid-run clears learned state
    do_reset();
    branch(200, 1'b1, got);
    chk(got == 1'b0, "R1 cleared after reset", got, 0);

    @(negedge clk);
    chk(q.size() == 0, "R2 all predictions seen", q.size(), 0);
    finish_run();
  end

endmodule